// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Cycle Timing Engine

This block runs a single programmed-I/O access on a parallel ATA bus, either to a task-file register or to the 16-bit data port. A host raises a one-cycle request that says read or write, register or data access, a 5-bit target select and the word to write. The engine puts the chip selects and the three address lines on the bus, waits a programmable setup time, and asserts the read or write strobe for a programmable active time. If the device holds its ready line low and ready checking is enabled, the strobe is held longer, up to a fixed ceiling. The engine then releases the strobe and waits out a recovery time before it reports completion.

All phase lengths count timing ticks given by the `tick` enable input. Two timing sets are supplied: one for 8-bit register accesses and one for 16-bit data accesses. The request's register flag picks the set, and the set is captured when the request is accepted. Read data is captured as the read strobe rises. Write data stays on the bus while the write strobe is low and for a hold time set by the PIO mode.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset and whenever `busy` is low, `cs_blk0_n`, `cs_blk1_n`, `rd_stb_n` and `wr_stb_n` are all high, and `bus_doe`, `done` and `busy` are low.
- R2: While `busy` is high, `bus_addr` equals select bits 4..2, `cs_blk1_n` equals select bit 1 and `cs_blk0_n` equals select bit 0. Command-block registers use select `(reg<<2)|2`, and the alternate-status/control register uses `(6<<2)|1`.
- R3: After acceptance, both strobes stay high with the address driven for max(`cfg_setup`,1) ticks.
- R4: A read pulls only `rd_stb_n` low and a write pulls only `wr_stb_n` low. Without stretching, the strobe stays low for max(act,1) ticks, where act is `cfg_act8` for register accesses (`req_reg`=1) and `cfg_act16` for data accesses.
- R5: Stretching applies when `cfg_rdy_en` is 1 and the base active time is below 51 ticks. If `dev_ready` is low at the last active tick, the strobe stays low until a tick edge samples `dev_ready` high. The total strobe-low time never exceeds 51 ticks.
- R6: Let T be the total strobe-low ticks. Recovery lasts (cycle − T) ticks when that value is positive and larger than the recovery count, and the recovery count otherwise. The 8-bit cycle and recovery counts apply to register accesses and the 16-bit ones to data accesses.
- R7: For a write, `bus_doe` is high and `bus_dout` equals the request data while `wr_stb_n` is low. Both are kept for H ticks after the strobe rises: H=3 for PIO mode 0, 2 for modes 1–2, and 1 for modes 3 and above. Recovery lasts at least H ticks.
- R8: For a read, `bus_doe` stays low, and `rdata` holds the value of `bus_din` sampled at the clock edge that raises `rd_stb_n`. It is valid when `done` pulses.
- R9: `busy` is high from the cycle after acceptance until recovery ends. `done` is then high for exactly one cycle, in which `busy` is already low.
- R10: A request is accepted only while idle. Request fields and timing inputs that change while busy have no effect on the running access.
- R11: A clock edge with `tick` low does not advance any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing tick enable |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = register access (8-bit set), 0 = data access (16-bit set) |
| req_sel | input | 5 | Target select {A2..A0, CS1 inactive, CS0 inactive} |
| req_wdata | input | DW | Write data |
| cfg_setup | input | TW | Setup ticks |
| cfg_cyc8 | input | TW | Register-access cycle ticks |
| cfg_act8 | input | TW | Register-access active ticks |
| cfg_rec8 | input | TW | Register-access recovery ticks |
| cfg_cyc16 | input | TW | Data-access cycle ticks |
| cfg_act16 | input | TW | Data-access active ticks |
| cfg_rec16 | input | TW | Data-access recovery ticks |
| cfg_pio_mode | input | 3 | PIO mode, selects write hold |
| cfg_rdy_en | input | 1 | Enable ready-line stretching |
| dev_ready | input | 1 | Device ready line, low = wait |
| bus_din | input | DW | Data bus input |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| cs_blk0_n | output | 1 | Chip select 0, active low |
| cs_blk1_n | output | 1 | Chip select 1, active low |
| bus_addr | output | 3 | Device address lines |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| bus_dout | output | DW | Data bus output |
| bus_doe | output | 1 | Data bus output enable |

## Verification
The bench measures every phase in cycles at the pins and aims at the places where the counts interact. These are: zero counts, which must still give one tick; a ready line stuck low, which must stop at exactly 51 ticks and not hang or stop early; a ready release at a chosen tick, which must give that exact strobe width; and a base active time already past the ceiling, which must not stretch at all. It also drives a recovery count smaller than the remaining cycle time, so a design that ignored the cycle rule would finish early. A write hold longer than the recovery must lengthen recovery rather than let the data bus drop. Timing and select inputs are scrambled mid-access, and ticks are held off during setup. A design that resampled its inputs or counted without ticks would show a moved address or a wrong setup width.

// File: rtl/pio_pkg.sv
// Shared types and helpers for the PIO cycle timing engine.
// Assumes: PIO mode codes 0..4 are meaningful; higher codes use the fastest hold.
package pio_pkg;

    // Phases of one bus access
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_WAITRDY = 3'd3,
        ST_RECOVER = 3'd4
    } pio_state_t;

    // Write-data hold ticks after the write strobe rises, by PIO mode
    function automatic logic [1:0] hold_for_mode(input logic [2:0] mode);
        logic [1:0] h;
        case (mode)
            3'd0:       h = 2'd3;
            3'd1, 3'd2: h = 2'd2;
            default:    h = 2'd1;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pio_req_latch.sv
// Captures the request and the matching timing set at acceptance.
// Assumes: 'accept' is high only in the idle phase; values are held until the next accept.
module pio_req_latch #(
    parameter int DW = 16,
    parameter int TW = 8,
    localparam int AW = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          req_write,
    input  logic          req_reg,
    input  logic [4:0]    req_sel,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] cfg_cyc8,
    input  logic [TW-1:0] cfg_act8,
    input  logic [TW-1:0] cfg_rec8,
    input  logic [TW-1:0] cfg_cyc16,
    input  logic [TW-1:0] cfg_act16,
    input  logic [TW-1:0] cfg_rec16,
    input  logic [2:0]    cfg_pio_mode,
    input  logic          cfg_rdy_en,
    output logic          lat_write,
    output logic [4:0]    lat_sel,
    output logic [DW-1:0] lat_wdata,
    output logic [TW-1:0] lat_cyc,
    output logic [AW-1:0] lat_act,
    output logic [TW-1:0] lat_rec,
    output logic [1:0]    lat_hold,
    output logic          lat_rdy_en
);
    import pio_pkg::*;

    logic [TW-1:0] act_pick;
    logic [AW-1:0] act_eff;

    // Pick the active count of the selected set and clamp it to at least one tick
    always_comb begin
        act_pick = req_reg ? cfg_act8 : cfg_act16;
        act_eff  = (act_pick == '0) ? AW'(1) : {1'b0, act_pick};
    end

    // Hold request fields and timing values for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write  <= 1'b0;
            lat_sel    <= 5'b00011;
            lat_wdata  <= '0;
            lat_cyc    <= '0;
            lat_act    <= AW'(1);
            lat_rec    <= '0;
            lat_hold   <= 2'd1;
            lat_rdy_en <= 1'b0;
        end else if (accept) begin
            lat_write  <= req_write;
            lat_sel    <= req_sel;
            lat_wdata  <= req_wdata;
            lat_cyc    <= req_reg ? cfg_cyc8 : cfg_cyc16;
            lat_act    <= act_eff;
            lat_rec    <= req_reg ? cfg_rec8 : cfg_rec16;
            lat_hold   <= hold_for_mode(cfg_pio_mode);
            lat_rdy_en <= cfg_rdy_en;
        end
    end

endmodule

// File: rtl/pio_recovery_calc.sv
// Computes the recovery length from the cycle, the active time spent and the
// minimum recovery, raised to the write hold for writes.
// Assumes: act_final is the total strobe-low tick count including any stretch.
module pio_recovery_calc #(
    parameter int TW = 8,
    localparam int AW = TW + 1
) (
    input  logic [TW-1:0] cyc,
    input  logic [AW-1:0] act_final,
    input  logic [TW-1:0] rec,
    input  logic [1:0]    hold,
    input  logic          is_write,
    output logic [AW-1:0] rec_len
);
    logic [AW-1:0] cyc_x;
    logic [AW-1:0] rec_x;
    logic [AW-1:0] hold_x;
    logic [AW-1:0] remain;
    logic [AW-1:0] rule_len;
    logic          gap_wins;

    // Choose the longer of the remaining cycle time and the minimum recovery
    always_comb begin
        cyc_x    = {1'b0, cyc};
        rec_x    = {1'b0, rec};
        hold_x   = AW'(hold);
        remain   = cyc_x - act_final;
        gap_wins = (cyc_x > act_final) && (remain > rec_x);
        rule_len = gap_wins ? remain : rec_x;
        rec_len  = (is_write && (hold_x > rule_len)) ? hold_x : rule_len;
    end

endmodule

// File: rtl/pio_bus_drive.sv
// Decodes the bus pins from the current phase and the captured request.
// Assumes: phase registers are the only state; outputs follow them directly.
module pio_bus_drive #(
    parameter int DW = 16
) (
    input  pio_pkg::pio_state_t state,
    input  logic                lat_write,
    input  logic [4:0]          lat_sel,
    input  logic [DW-1:0]       lat_wdata,
    input  logic [1:0]          hold_cnt,
    output logic                cs_blk0_n,
    output logic                cs_blk1_n,
    output logic [2:0]          bus_addr,
    output logic                rd_stb_n,
    output logic                wr_stb_n,
    output logic [DW-1:0]       bus_dout,
    output logic                bus_doe
);
    import pio_pkg::*;

    logic engaged;
    logic strobe_on;

    // Translate phase and select code into chip selects, address, strobes and data enable
    always_comb begin
        engaged   = (state != ST_IDLE);
        strobe_on = (state == ST_ACTIVE) || (state == ST_WAITRDY);
        cs_blk0_n = engaged ? lat_sel[0] : 1'b1;
        cs_blk1_n = engaged ? lat_sel[1] : 1'b1;
        bus_addr  = engaged ? lat_sel[4:2] : 3'd0;
        rd_stb_n  = !(strobe_on && !lat_write);
        wr_stb_n  = !(strobe_on && lat_write);
        bus_dout  = lat_wdata;
        bus_doe   = lat_write &&
                    (strobe_on || ((state == ST_RECOVER) && (hold_cnt != 2'd0)));
    end

endmodule

// File: rtl/pio_cycle_engine.sv
// Top of the PIO cycle timing engine: sequences setup, active, optional
// ready stretch and recovery for one register or data access per request.
// Assumes: 'tick' is a single-cycle enable from a shared timebase; timing
// inputs are only meaningful at acceptance.
module pio_cycle_engine #(
    parameter int DW        = 16,
    parameter int TW        = 8,
    parameter int RDY_LIMIT = 51
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_reg,
    input  logic [4:0]    req_sel,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_cyc8,
    input  logic [TW-1:0] cfg_act8,
    input  logic [TW-1:0] cfg_rec8,
    input  logic [TW-1:0] cfg_cyc16,
    input  logic [TW-1:0] cfg_act16,
    input  logic [TW-1:0] cfg_rec16,
    input  logic [2:0]    cfg_pio_mode,
    input  logic          cfg_rdy_en,
    input  logic          dev_ready,
    input  logic [DW-1:0] bus_din,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          cs_blk0_n,
    output logic          cs_blk1_n,
    output logic [2:0]    bus_addr,
    output logic          rd_stb_n,
    output logic          wr_stb_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe
);
    import pio_pkg::*;

    localparam int AW = TW + 1;
    localparam logic [AW-1:0] LIM = AW'(RDY_LIMIT);
    localparam logic [AW-1:0] ONE = AW'(1);

    pio_state_t    state;
    logic [AW-1:0] cnt;
    logic [AW-1:0] act_tot;
    logic [1:0]    hold_cnt;

    logic          accept;
    logic          lat_write;
    logic [4:0]    lat_sel;
    logic [DW-1:0] lat_wdata;
    logic [TW-1:0] lat_cyc;
    logic [AW-1:0] lat_act;
    logic [TW-1:0] lat_rec;
    logic [1:0]    lat_hold;
    logic          lat_rdy_en;

    logic          cnt_last;
    logic          stretch_go;
    logic          rdy_exit;
    logic          release_now;
    logic [AW-1:0] act_final;
    logic [AW-1:0] rec_len;

    // Accept a request only when idle
    always_comb accept = (state == ST_IDLE) && req_valid;

    pio_req_latch #(.DW(DW), .TW(TW)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .req_write    (req_write),
        .req_reg      (req_reg),
        .req_sel      (req_sel),
        .req_wdata    (req_wdata),
        .cfg_cyc8     (cfg_cyc8),
        .cfg_act8     (cfg_act8),
        .cfg_rec8     (cfg_rec8),
        .cfg_cyc16    (cfg_cyc16),
        .cfg_act16    (cfg_act16),
        .cfg_rec16    (cfg_rec16),
        .cfg_pio_mode (cfg_pio_mode),
        .cfg_rdy_en   (cfg_rdy_en),
        .lat_write    (lat_write),
        .lat_sel      (lat_sel),
        .lat_wdata    (lat_wdata),
        .lat_cyc      (lat_cyc),
        .lat_act      (lat_act),
        .lat_rec      (lat_rec),
        .lat_hold     (lat_hold),
        .lat_rdy_en   (lat_rdy_en)
    );

    // Phase-end and strobe-release decisions for the current tick
    always_comb begin
        cnt_last    = (cnt <= ONE);
        stretch_go  = lat_rdy_en && !dev_ready && (act_tot < LIM);
        rdy_exit    = dev_ready || ((act_tot + ONE) >= LIM);
        release_now = tick &&
                      (((state == ST_ACTIVE) && cnt_last && !stretch_go) ||
                       ((state == ST_WAITRDY) && rdy_exit));
        act_final   = (state == ST_WAITRDY) ? (act_tot + ONE) : act_tot;
    end

    pio_recovery_calc #(.TW(TW)) u_recov (
        .cyc       (lat_cyc),
        .act_final (act_final),
        .rec       (lat_rec),
        .hold      (lat_hold),
        .is_write  (lat_write),
        .rec_len   (rec_len)
    );

    // Phase sequencer with a shared down-counter and strobe-time accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            act_tot  <= '0;
            hold_cnt <= 2'd0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (release_now) begin
                state    <= ST_RECOVER;
                cnt      <= rec_len;
                act_tot  <= act_final;
                hold_cnt <= lat_write ? lat_hold : 2'd0;
                if (!lat_write) begin
                    rdata <= bus_din;
                end
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (accept) begin
                            state <= ST_SETUP;
                            cnt   <= {1'b0, cfg_setup};
                        end
                    end
                    ST_SETUP: begin
                        if (tick) begin
                            if (cnt_last) begin
                                state   <= ST_ACTIVE;
                                cnt     <= lat_act;
                                act_tot <= lat_act;
                            end else begin
                                cnt <= cnt - ONE;
                            end
                        end
                    end
                    ST_ACTIVE: begin
                        if (tick) begin
                            if (cnt_last) begin
                                state <= ST_WAITRDY;
                            end else begin
                                cnt <= cnt - ONE;
                            end
                        end
                    end
                    ST_WAITRDY: begin
                        if (tick) begin
                            act_tot <= act_tot + ONE;
                        end
                    end
                    ST_RECOVER: begin
                        if (tick) begin
                            if (hold_cnt != 2'd0) begin
                                hold_cnt <= hold_cnt - 2'd1;
                            end
                            if (cnt_last) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end else begin
                                cnt <= cnt - ONE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Busy covers every phase except idle
    always_comb busy = (state != ST_IDLE);

    pio_bus_drive #(.DW(DW)) u_drive (
        .state     (state),
        .lat_write (lat_write),
        .lat_sel   (lat_sel),
        .lat_wdata (lat_wdata),
        .hold_cnt  (hold_cnt),
        .cs_blk0_n (cs_blk0_n),
        .cs_blk1_n (cs_blk1_n),
        .bus_addr  (bus_addr),
        .rd_stb_n  (rd_stb_n),
        .wr_stb_n  (wr_stb_n),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe)
    );

endmodule

// File: rtl/pio_cycle_engine_chk.sv
// Protocol checker for the PIO cycle timing engine, bound to the top.
// Assumes: observes top-level pins only.
module pio_cycle_engine_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          busy,
    input logic          done,
    input logic          cs_blk0_n,
    input logic          cs_blk1_n,
    input logic [2:0]    bus_addr,
    input logic          rd_stb_n,
    input logic          wr_stb_n,
    input logic [DW-1:0] bus_dout,
    input logic          bus_doe
);

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_blk0_n && cs_blk1_n && rd_stb_n && wr_stb_n && !bus_doe)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_stb_n && !wr_stb_n)); // R4

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_n |-> !bus_doe); // R8

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_n |-> bus_doe); // R7

    AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb_n && $past(!wr_stb_n)) |-> $stable(bus_dout)); // R7

    AST_SELECT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(cs_blk0_n) && $stable(cs_blk1_n))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> ($stable(rd_stb_n) && $stable(wr_stb_n))); // R11

endmodule

bind pio_cycle_engine pio_cycle_engine_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .busy      (busy),
    .done      (done),
    .cs_blk0_n (cs_blk0_n),
    .cs_blk1_n (cs_blk1_n),
    .bus_addr  (bus_addr),
    .rd_stb_n  (rd_stb_n),
    .wr_stb_n  (wr_stb_n),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe)
);

// File: tb/sim_pio_cycle_engine.sv
`timescale 1ns/1ps
module sim_pio_cycle_engine;

    localparam int DW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_reg = 1'b0;
    logic [4:0]    req_sel = 5'd0;
    logic [DW-1:0] req_wdata = '0;
    logic [TW-1:0] cfg_setup = '0, cfg_cyc8 = '0, cfg_act8 = '0, cfg_rec8 = '0;
    logic [TW-1:0] cfg_cyc16 = '0, cfg_act16 = '0, cfg_rec16 = '0;
    logic [2:0]    cfg_pio_mode = 3'd0;
    logic          cfg_rdy_en = 1'b0;
    logic          dev_ready = 1'b1;
    logic [DW-1:0] bus_din = '0;
    logic          busy, done, cs_blk0_n, cs_blk1_n, rd_stb_n, wr_stb_n, bus_doe;
    logic [DW-1:0] rdata, bus_dout;
    logic [2:0]    bus_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pio_cycle_engine #(.DW(DW), .TW(TW), .RDY_LIMIT(51)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
        .req_write(req_write), .req_reg(req_reg), .req_sel(req_sel),
        .req_wdata(req_wdata), .cfg_setup(cfg_setup), .cfg_cyc8(cfg_cyc8),
        .cfg_act8(cfg_act8), .cfg_rec8(cfg_rec8), .cfg_cyc16(cfg_cyc16),
        .cfg_act16(cfg_act16), .cfg_rec16(cfg_rec16), .cfg_pio_mode(cfg_pio_mode),
        .cfg_rdy_en(cfg_rdy_en), .dev_ready(dev_ready), .bus_din(bus_din),
        .busy(busy), .done(done), .rdata(rdata), .cs_blk0_n(cs_blk0_n),
        .cs_blk1_n(cs_blk1_n), .bus_addr(bus_addr), .rd_stb_n(rd_stb_n),
        .wr_stb_n(wr_stb_n), .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int hold_exp(input int mode);
        if (mode == 0) return 3;
        if (mode <= 2) return 2;
        return 1;
    endfunction

    // x: -1 ready always high, 0 ready never rises, >0 rises when strobe-low count reaches x
    function automatic int act_exp(input int a, input bit en, input int x);
        if (!en || a >= 51 || x < 0) return a;
        if (x == 0) return 51;
        if (x < a) return a;
        if (x > 51) return 51;
        return x;
    endfunction

    function automatic int rec_exp(input int c, input int t, input int r, input int h);
        int rule;
        rule = (c > t && (c - t) > r) ? (c - t) : r;
        return imax(imax(rule, h), 1);
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " R1 idle pins"},
            {cs_blk0_n, cs_blk1_n, rd_stb_n, wr_stb_n, bus_doe, busy, done}, 7'b1111000);
    endtask

    task automatic run_txn(input bit w, input bit rg, input logic [4:0] sel,
                           input logic [15:0] wd, input int ts,
                           input int c8, input int a8, input int r8,
                           input int c16, input int a16, input int r16,
                           input int mode, input bit en, input int x,
                           input int stall, input bit spam);
        int sc, ac, rc, oc, addr_bad, dir_bad, wd_bad, a, exp_a, c, r, h;
        logic [15:0] din;
        bit got;
        sc = 0; ac = 0; rc = 0; oc = 0; addr_bad = 0; dir_bad = 0; wd_bad = 0; got = 0;
        @(negedge clk);
        req_write = w; req_reg = rg; req_sel = sel; req_wdata = wd;
        cfg_setup = TW'(ts); cfg_cyc8 = TW'(c8); cfg_act8 = TW'(a8); cfg_rec8 = TW'(r8);
        cfg_cyc16 = TW'(c16); cfg_act16 = TW'(a16); cfg_rec16 = TW'(r16);
        cfg_pio_mode = 3'(mode); cfg_rdy_en = en;
        din = 16'($urandom); bus_din = din;
        dev_ready = (x < 0);
        tick = 1'b1;
        req_valid = 1'b1;
        for (int k = 1; k <= 3000; k++) begin
            @(negedge clk);
            if (!spam) req_valid = 1'b0;
            if (spam && k == 1) begin
                req_sel = ~sel; req_write = ~w; req_reg = ~rg; req_wdata = ~wd;
                cfg_setup = TW'($urandom); cfg_act8 = TW'($urandom); cfg_act16 = TW'($urandom);
                cfg_cyc8 = TW'($urandom); cfg_cyc16 = TW'($urandom);
                cfg_rec8 = TW'($urandom); cfg_rec16 = TW'($urandom);
                cfg_pio_mode = 3'($urandom); cfg_rdy_en = ~en;
            end
            tick = (k <= stall) ? 1'b0 : 1'b1;
            if (done) begin
                req_valid = 1'b0;
                got = 1'b1;
                break;
            end
            if (!busy) dir_bad++;
            if ({bus_addr, cs_blk1_n, cs_blk0_n} != sel) addr_bad++;
            if (!rd_stb_n || !wr_stb_n) begin
                ac++;
                if (w ? (wr_stb_n || !rd_stb_n) : (rd_stb_n || !wr_stb_n)) dir_bad++;
                if (w && (!bus_doe || bus_dout != wd)) wd_bad++;
                if (!w && bus_doe) wd_bad++;
                if (x > 0 && ac == x) dev_ready = 1'b1;
            end else if (ac == 0) begin
                sc++;
            end else begin
                rc++;
                if (bus_doe) begin
                    oc++;
                    if (bus_dout != wd) wd_bad++;
                end
            end
        end
        req_valid = 1'b0;
        tick = 1'b1;
        if (!got) begin
            n_chk++; n_bad++;
            $display("FAIL R9 no done pulse: actual 0 expected 1");
        end
        a = imax(rg ? a8 : a16, 1);
        exp_a = act_exp(a, en, x);
        c = rg ? c8 : c16;
        r = rg ? r8 : r16;
        h = w ? hold_exp(mode) : 0;
        chk(spam ? "R10 select held" : "R2 select pins", addr_bad, 0);
        chk("R4 strobe direction / R9 busy", dir_bad, 0);
        chk(stall > 0 ? "R11 setup with stalled ticks" : "R3 setup width", sc, imax(ts, 1) + stall);
        chk((en && a < 51) ? "R5 stretched active width" : "R4 active width", ac, exp_a);
        chk("R6 recovery width", rc, rec_exp(c, exp_a, r, h));
        chk("R7 data hold ticks", oc, h);
        chk("R7 write data drive", wd_bad, 0);
        if (!w) chk("R8 read data", int'(rdata), int'(din));
        @(negedge clk);
        check_idle("after access");
        dev_ready = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("post reset");

        // command register write, mode 0: hold 3 exceeds rule (5-3=2 > 1)
        run_txn(1, 1, 5'((7 << 2) | 2), 16'h00EC, 2, 5, 3, 1, 20, 9, 4, 0, 0, -1, 0, 0);
        // alternate status read on the other chip select
        run_txn(0, 1, 5'((6 << 2) | 1), 16'h0, 3, 12, 4, 2, 20, 9, 4, 2, 0, -1, 0, 0);
        // data write using the 16-bit set, mode 4
        run_txn(1, 0, 5'(2), 16'hA55A, 1, 30, 30, 30, 14, 6, 3, 4, 0, -1, 0, 0);
        // all counts zero: every phase one tick
        run_txn(0, 0, 5'(2), 16'h0, 0, 0, 0, 0, 0, 0, 0, 3, 0, -1, 0, 0);
        // ready stuck low: capped at 51
        run_txn(0, 0, 5'(2), 16'h0, 1, 0, 0, 0, 60, 10, 2, 1, 1, 0, 0, 0);
        // ready released at strobe tick 20
        run_txn(1, 0, 5'(2), 16'h1234, 1, 0, 0, 0, 30, 10, 2, 1, 1, 20, 0, 0);
        // base active already past the ceiling: no stretch
        run_txn(0, 1, 5'(10), 16'h0, 1, 70, 60, 2, 0, 0, 0, 1, 1, 0, 0, 0);
        // ready low but stretching disabled
        run_txn(0, 0, 5'(2), 16'h0, 2, 0, 0, 0, 8, 3, 1, 2, 0, 0, 0, 0);
        // ticks held off for 4 cycles during setup
        run_txn(1, 1, 5'(18), 16'h00FF, 3, 10, 3, 2, 0, 0, 0, 2, 0, -1, 4, 0);
        // inputs scrambled while busy
        run_txn(1, 0, 5'(2), 16'hBEEF, 2, 40, 40, 40, 12, 4, 2, 1, 1, 6, 0, 1);
        run_txn(0, 1, 5'(26), 16'h0, 2, 9, 3, 1, 40, 40, 40, 0, 0, -1, 0, 1);

        for (int i = 0; i < 150; i++) begin
            int xs;
            bit en;
            en = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: xs = -1;
                1: xs = 0;
                default: xs = int'($urandom % 60) + 1;
            endcase
            run_txn(1'($urandom), 1'($urandom), 5'($urandom), 16'($urandom),
                    int'($urandom % 8), int'($urandom % 40), int'($urandom % 20),
                    int'($urandom % 12), int'($urandom % 40), int'($urandom % 20),
                    int'($urandom % 12), int'($urandom % 8), en, xs,
                    (($urandom % 5) == 0) ? int'($urandom % 4) : 0,
                    1'(($urandom % 6) == 0));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule